// File: doc/BRIEF.md
# Oscillator Trim Code Search Sequencer

This block calibrates an oscillator that has an eight-step trim setting. On a start request it walks the trim code upward from 0 to 7 and drives the same code onto two trim outputs. Before any counter request for a code, it waits a programmable number of cycles so the oscillator can settle. It then asks an external frequency counter for ten gated counts, one at a time, using a start pulse and a done strobe.

For each code the block drops the largest and smallest of the ten counts and averages the other eight. It compares that average against a programmable target count; 4949 suits a gate of 4096 reference cycles. The code whose average lies closest to the target is kept. When the sweep ends, the chosen code and its residual error are presented together with a one-cycle done pulse. A sticky calibrated flag, cleared only by reset, blocks any further sweep.

Top module: `osc_trim_seq`

## Requirements
- R1: After reset, `done`, `calibrated` and `meas_start` are 0, and `trim_a`, `trim_b`, `best_code` and `best_err` are all 0.
- R2: A sweep presents codes 0,1,...,7 in ascending order, each exactly once, and `trim_a` always equals `trim_b`.
- R3: Each code receives exactly 10 one-cycle `meas_start` pulses. No further pulse is raised until the `meas_done` strobe for the previous request has been seen.
- R4: A code's wait starts in the cycle after `start` is accepted (code 0) or in the first cycle the trim outputs carry the new code (codes 1 to 7). Its first `meas_start` appears exactly `settle_cycles`+1 cycles after that first cycle.
- R5: A code's average is (sum of its 10 counts − largest − smallest), computed modulo 2^32 and shifted right by 3.
- R6: A code's error is |average − `target`|.
- R7: `best_code` is the code with the smallest error. On equal errors the lower code wins, because a later code replaces the best only when its error is strictly smaller. `best_err` is that code's error.
- R8: `done` is high for exactly one cycle per sweep, after the last code is evaluated. `best_code` and `best_err` are final in that cycle, `calibrated` rises in that cycle, and `calibrated` stays high until reset.
- R9: `start` is ignored while a sweep is running and at any time once `calibrated` is set. No `meas_start`, no `done`, and no change to `best_code` or `best_err` follows from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a calibration sweep |
| target | input | 32 | Desired count per gate |
| settle_cycles | input | 16 | Settling wait before each code's first measurement |
| meas_start | output | 1 | One-cycle request for one counter measurement |
| meas_done | input | 1 | Counter strobe; `meas_count` is valid with it |
| meas_count | input | 32 | Measured count |
| trim_a | output | 3 | Trim code to the oscillator |
| trim_b | output | 3 | Second copy of the trim code |
| done | output | 1 | One-cycle end-of-sweep pulse |
| calibrated | output | 1 | Sticky sweep-completed flag |
| best_code | output | 3 | Selected trim code |
| best_err | output | 32 | Residual error of the selected code |

## Verification
A wrong sample counter or a wrong wait counter shows at the ports within one code period: the number of requests per code differs from ten, or the first request arrives at the wrong cycle. A fault in the max/min trackers or in the sum does not show until `done`. At that point it appears as a wrong `best_err`, or as a wrong `best_code` when outlier counts are placed on purpose. A broken tie rule or a broken sticky flag only shows under directed patterns: equal errors on two codes, and a second start after completion.

// File: rtl/osc_trim_seq.sv
module osc_trim_seq #(
  parameter int CODE_W     = 3,
  parameter int CNT_W      = 32,
  parameter int WAIT_W     = 16,
  parameter int DROP_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  target,
  input  logic [WAIT_W-1:0] settle_cycles,
  output logic              meas_start,
  input  logic              meas_done,
  input  logic [CNT_W-1:0]  meas_count,
  output logic [CODE_W-1:0] trim_a,
  output logic [CODE_W-1:0] trim_b,
  output logic              done,
  output logic              calibrated,
  output logic [CODE_W-1:0] best_code,
  output logic [CNT_W-1:0]  best_err
);
  localparam int NSAMP     = (1 << DROP_SHIFT) + 2;
  localparam int SAMP_W    = $clog2(NSAMP + 1);
  localparam int LAST_CODE = (1 << CODE_W) - 1;

  typedef enum logic [2:0] {IDLE, SETTLE, MSTART, MWAIT, EVAL} st_t;
  st_t state;

  logic [CODE_W-1:0] code;
  logic [WAIT_W-1:0] wcnt;
  logic [SAMP_W-1:0] nsamp;
  logic [CNT_W-1:0]  sum, vmax, vmin;
  logic              done_r, cal_r;
  logic [CODE_W-1:0] bcode_r;
  logic [CNT_W-1:0]  berr_r;

  // R5: trimmed mean, R6: absolute distance
  logic [CNT_W-1:0] adj, mean, err;
  assign adj  = sum - vmax - vmin;
  assign mean = adj >> DROP_SHIFT;
  assign err  = (mean > target) ? (mean - target) : (target - mean);

  logic last_samp, last_code, better;
  assign last_samp = (nsamp == SAMP_W'(NSAMP - 1));
  assign last_code = (code == CODE_W'(LAST_CODE));
  assign better    = (code == '0) || (err < berr_r);  // R7: strict less keeps lower code

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      code    <= '0;
      wcnt    <= '0;
      nsamp   <= '0;
      sum     <= '0;
      vmax    <= '0;
      vmin    <= '1;
      done_r  <= 1'b0;
      cal_r   <= 1'b0;
      bcode_r <= '0;
      berr_r  <= '0;
    end else begin
      done_r <= 1'b0;
      case (state)
        IDLE: if (start && !cal_r) begin  // R9
          code  <= '0;
          wcnt  <= '0;
          state <= SETTLE;
        end
        SETTLE: if (wcnt == settle_cycles) begin  // R4
          nsamp <= '0;
          sum   <= '0;
          vmax  <= '0;
          vmin  <= '1;
          state <= MSTART;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
        MSTART: state <= MWAIT;
        MWAIT: if (meas_done) begin  // R3
          sum   <= sum + meas_count;
          if (meas_count > vmax) vmax <= meas_count;
          if (meas_count < vmin) vmin <= meas_count;
          nsamp <= nsamp + 1'b1;
          state <= last_samp ? EVAL : MSTART;
        end
        EVAL: begin
          if (better) begin
            bcode_r <= code;
            berr_r  <= err;
          end
          if (last_code) begin  // R8
            done_r <= 1'b1;
            cal_r  <= 1'b1;
            state  <= IDLE;
          end else begin  // R2
            code  <= code + 1'b1;
            wcnt  <= '0;
            state <= SETTLE;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign meas_start = (state == MSTART);
  assign trim_a     = code;
  assign trim_b     = code;
  assign done       = done_r;
  assign calibrated = cal_r;
  assign best_code  = bcode_r;
  assign best_err   = berr_r;
endmodule

// File: rtl/osc_trim_seq_chk.sv
module osc_trim_seq_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              meas_start,
  input logic              meas_done,
  input logic [CODE_W-1:0] trim_a,
  input logic [CODE_W-1:0] trim_b,
  input logic              done,
  input logic              calibrated
);
  AST_TRIM_PAIR: assert property (@(posedge clk) disable iff (!rst_n) trim_a == trim_b); // R2
  AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_a != $past(trim_a)) |-> (trim_a == CODE_W'($past(trim_a) + 1'b1))); // R2
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) meas_start |=> !meas_start); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_CAL: assert property (@(posedge clk) disable iff (!rst_n) done |-> calibrated); // R8
  AST_CAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) calibrated |=> calibrated); // R8
  AST_QUIET_AFTER_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    (calibrated && !done) |-> !meas_start); // R9
endmodule

bind osc_trim_seq osc_trim_seq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .meas_start(meas_start), .meas_done(meas_done),
  .trim_a(trim_a), .trim_b(trim_b), .done(done), .calibrated(calibrated)
);

// File: tb/tb_osc_trim_seq.sv
module tb_osc_trim_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] target = 32'd4949;
  logic [15:0] settle_cycles = 16'd0;
  logic        meas_start;
  logic        meas_done = 1'b0;
  logic [31:0] meas_count = '0;
  logic [2:0]  trim_a, trim_b, best_code;
  logic        done, calibrated;
  logic [31:0] best_err;

  osc_trim_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .target(target),
    .settle_cycles(settle_cycles), .meas_start(meas_start),
    .meas_done(meas_done), .meas_count(meas_count), .trim_a(trim_a),
    .trim_b(trim_b), .done(done), .calibrated(calibrated),
    .best_code(best_code), .best_err(best_err)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // counter model
  int mode = 0;
  logic [31:0] samp [8][10];
  int sidx [8];
  int pend = 0;

  function automatic logic [31:0] gen(int m, int c, int i);
    case (m)
      1: begin
        if (c == 2) return target - 10;
        if (c == 5) return target + 10;
        return target + 1000 + c;
      end
      2: begin
        if (c == 6) return (i == 3) ? 32'd100000 : (i == 7) ? 32'd0 : target;
        return target + 500 + 3 * c;
      end
      default: begin
        logic [31:0] v;
        v = 32'd4200 + 32'(c) * 32'd230 + 32'($urandom_range(0, 80));
        if ($urandom_range(0, 9) == 0) v = v + 32'd3000;
        if ($urandom_range(0, 9) == 0) v = v - 32'd2500;
        return v;
      end
    endcase
  endfunction

  always @(negedge clk) begin
    meas_done <= 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        logic [31:0] v;
        v = gen(mode, int'(trim_a), sidx[trim_a]);
        if (sidx[trim_a] < 10) samp[trim_a][sidx[trim_a]] = v;
        sidx[trim_a]++;
        meas_done  <= 1'b1;
        meas_count <= v;
      end
    end else if (meas_start) begin
      pend = $urandom_range(1, 5);
    end
  end

  function automatic void expect_best(output logic [2:0] bc, output logic [31:0] be);
    bc = 0; be = 0;
    for (int c = 0; c < 8; c++) begin
      logic [31:0] s, mx, mn, mean, e;
      s = 0; mx = 0; mn = '1;
      for (int i = 0; i < 10; i++) begin
        s = s + samp[c][i];
        if (samp[c][i] > mx) mx = samp[c][i];
        if (samp[c][i] < mn) mn = samp[c][i];
      end
      mean = (s - mx - mn) >> 3;
      e = (mean > target) ? mean - target : target - mean;
      if (c == 0 || e < be) begin bc = 3'(c); be = e; end
    end
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run(input int m, input logic [31:0] tgt, input logic [15:0] s, input bit poke);
    int starts [8];
    int cyc, entry, dones;
    logic [2:0] prev, bc;
    logic [31:0] be;
    bit got;
    mode = m; target = tgt; settle_cycles = s;
    for (int c = 0; c < 8; c++) begin starts[c] = 0; sidx[c] = 0; end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; entry = 0; dones = 0; prev = trim_a; got = 0;
    while (cyc < 20000 && !got) begin
      if (trim_a != trim_b) chk(0, "R2 trim copies", trim_b, trim_a);
      if (trim_a != prev) begin
        chk(trim_a == 3'(prev + 1), "R2 ascending code", trim_a, 3'(prev + 1));
        entry = cyc; prev = trim_a;
      end
      if (meas_start) begin
        if (starts[trim_a] == 0)
          chk(cyc - entry == int'(s) + 1, "R4 settle wait", cyc - entry, int'(s) + 1);
        starts[trim_a]++;
      end
      if (done) begin
        dones++; got = 1;
        expect_best(bc, be);
        chk(best_code == bc, "R7 best code", best_code, bc);
        chk(best_err == be, "R5 R6 best error", best_err, be);
        chk(calibrated, "R8 calibrated with done", calibrated, 1);
        chk(trim_a == 3'd7, "R2 last code", trim_a, 7);
      end
      start = (poke && cyc == 40);  // R9 start while busy
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(got, "R8 done seen", got, 1);
    chk(!done, "R8 done one cycle", done, 0);
    for (int c = 0; c < 8; c++)
      chk(starts[c] == 10, "R3 requests per code", starts[c], 10);
    chk(dones == 1, "R8 single done", dones, 1);
  endtask

  initial begin
    void'($urandom(32'd7321));
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(!done && !calibrated && !meas_start, "R1 flags", {done, calibrated, meas_start}, 0);
    chk(trim_a == 0 && trim_b == 0, "R1 trim", trim_a, 0);
    chk(best_code == 0 && best_err == 0, "R1 best", best_err, 0);

    run(0, 32'd4949, 16'd3, 1'b1);
    begin
      logic [2:0] bc0; logic [31:0] be0;
      bit seen;
      bc0 = best_code; be0 = best_err; seen = 0;
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (60) begin
        if (meas_start || done) seen = 1;
        @(negedge clk);
      end
      chk(!seen, "R9 start ignored after calibration", seen, 0);
      chk(best_code == bc0 && best_err == be0, "R9 result held", best_err, be0);
      chk(calibrated, "R8 sticky calibrated", calibrated, 1);
    end

    do_reset();
    chk(!calibrated, "R1 reset clears calibrated", calibrated, 0);
    run(1, 32'd5000, 16'd0, 1'b0);
    chk(best_code == 3'd2, "R7 tie goes to lower code", best_code, 2);
    chk(best_err == 32'd10, "R6 tie error", best_err, 10);

    do_reset();
    run(2, 32'd4949, 16'd7, 1'b0);
    chk(best_code == 3'd6, "R5 outliers dropped", best_code, 6);
    chk(best_err == 32'd0, "R5 exact mean", best_err, 0);

    for (int k = 0; k < 4; k++) begin
      do_reset();
      run(0, 32'd4300 + 32'($urandom_range(0, 1800)), 16'($urandom_range(0, 20)), k[0]);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule